// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block lets a processor drive an 8-bit asynchronous NAND flash through a single 32-bit register. Each bus write carries three things: an operation code, a chip-enable request and one byte. The block turns that write into the matching cycle on the flash pins. That cycle is a command latch, an address latch or a data write, each with a programmable write-strobe width and one clock of setup and hold around the strobe.

A write with the read-arm operation code puts the bridge in read mode. From then on, every register read fires one read strobe on the flash. The read returns the sampled byte in the same field that writes use. Every register read also reports the flash ready/busy line, after that line has passed a synchronizer.

The bus side is a plain request/acknowledge. The master holds a read or write request until `bus_ready_o` pulses for one clock. Read data is valid in that same clock.

Top module: `nand_reg_bridge`

## Requirements
- R1: Reset forces idle: `nand_ce_no`, `nand_we_no` and `nand_re_no` are high; `nand_cle_o`, `nand_ale_o`, `nand_dq_oe_o` and `bus_ready_o` are low; read mode is cleared.
- R2: A written word with opcode 0 in bits 30:28 produces exactly one WE# low pulse. During it CLE is 1, ALE is 0, and bits 23:16 of the word are on `nand_dq_o`.
- R3: Opcode 1 produces exactly one WE# low pulse with ALE 1, CLE 0 and bits 23:16 on the data bus.
- R4: Opcode 3 produces exactly one WE# low pulse with CLE and ALE both 0 and bits 23:16 on the data bus. A multi-byte transfer is one register write per byte.
- R5: `nand_ce_no` is low exactly when bit 31 of the most recently accepted written word was 1. This holds for every opcode.
- R6: WE# stays low for `WE_LOW_CYC` clocks. Data, CLE, ALE and the drive enable are stable for at least one clock before WE# falls and stay unchanged in the clock in which WE# rises.
- R7: `nand_dq_oe_o` is 1 only during command, address and data-write cycles. It is never 1 while RE# is low or while the bridge is idle.
- R8: After a write with opcode 2, each register read produces one RE# low pulse of `RE_LOW_CYC` clocks. The read returns the flash byte sampled in the last low clock, placed in bits 23:16.
- R9: Without read mode, a register read produces no RE# pulse and returns 0 in bits 23:16. Opcodes 0, 1 and 3 clear read mode.
- R10: Bit 15 of read data is 1 when the synchronized `nand_rb_ni` is low (busy) and 0 when it is high. Bits 31:24 and 14:0 of read data are 0.
- R11: Opcodes 4 to 7 produce no flash cycle and leave read mode unchanged. They still update chip enable from bit 31.
- R12: Each accepted request is answered by `bus_ready_o` high for exactly one clock. A write has priority when both requests are present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write request, held until acknowledged |
| bus_rd_i | input | 1 | Read request, held until acknowledged |
| bus_wdata_i | input | 32 | Write word: bit 31 chip enable, 30:28 opcode, 23:16 byte |
| bus_rdata_o | output | 32 | Read word: 23:16 byte, bit 15 busy |
| bus_ready_o | output | 1 | One-clock acknowledge; read data valid |
| nand_ce_no | output | 1 | Flash chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus drive enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_ni | input | 1 | Ready/busy, low while busy |

## Verification
The bench builds the bridge with `WE_LOW_CYC` = 2 and `RE_LOW_CYC` = 4, while the synchronizer depth keeps its default. With unequal strobe widths, both different from the default, a design that uses one counter limit for both strobes is caught by the measured pulse width. So is a design that ignores the parameter. The scoreboard compares the latch-signal and byte of every write pulse against the queued expectation. This exposes swapped CLE/ALE decoding, stray pulses from reserved or read-arm opcodes, and a wrong byte lane.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CE_BIT   = 31;
  localparam int unsigned OP_LSB   = 28;
  localparam int unsigned OP_W     = 3;
  localparam int unsigned BYTE_LSB = 16;
  localparam int unsigned BUSY_BIT = 15;

  typedef enum logic [OP_W-1:0] {
    OP_CMD    = 3'd0,
    OP_ADDR   = 3'd1,
    OP_ARM_RD = 3'd2,
    OP_WRITE  = 3'd3
  } op_e;

  typedef enum logic [1:0] {XF_CMD, XF_ADDR, XF_DATA, XF_READ} xfer_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_STROBE, SQ_HOLD} seq_state_e;

  function automatic logic [WORD_W-1:0] pack_rd(input logic [BYTE_W-1:0] b, input logic busy);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BYTE_LSB +: BYTE_W] = b;
    w[BUSY_BIT] = busy;
    return w;
  endfunction
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sq;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '1;
        else         sq <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '1;
        else         sq <= {sq[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = sq[STAGES-1];
endmodule

// File: rtl/nand_pin_seq.sv
module nand_pin_seq
  import nand_bridge_pkg::*;
#(
  parameter int unsigned WE_LOW_CYC = 3,
  parameter int unsigned RE_LOW_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  xfer_e             kind_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [BYTE_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int unsigned MAX_LOW = (WE_LOW_CYC > RE_LOW_CYC) ? WE_LOW_CYC : RE_LOW_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_LOW + 1);
  localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] RE_LAST = CNT_W'(RE_LOW_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
      cle_o   <= 1'b0;
      ale_o   <= 1'b0;
      we_no   <= 1'b1;
      re_no   <= 1'b1;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            cnt_q <= '0;
            if (kind_i == XF_READ) begin
              is_rd_q <= 1'b1;
              re_no   <= 1'b0;
              state_q <= SQ_STROBE;
            end else begin
              is_rd_q <= 1'b0;
              cle_o   <= (kind_i == XF_CMD);
              ale_o   <= (kind_i == XF_ADDR);
              dq_o    <= byte_i;
              dq_oe_o <= 1'b1;
              state_q <= SQ_SETUP;
            end
          end
        end
        SQ_SETUP: begin
          we_no   <= 1'b0;
          cnt_q   <= '0;
          state_q <= SQ_STROBE;
        end
        SQ_STROBE: begin
          if (is_rd_q) begin
            if (cnt_q == RE_LAST) begin
              re_no   <= 1'b1;
              state_q <= SQ_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else if (cnt_q == WE_LAST) begin
            we_no   <= 1'b1;
            state_q <= SQ_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_HOLD: begin
          cle_o   <= 1'b0;
          ale_o   <= 1'b0;
          dq_oe_o <= 1'b0;
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // completion: end of write hold, or last read-low clock (bus sampled here)
  assign done_o = (state_q == SQ_HOLD) ||
                  ((state_q == SQ_STROBE) && is_rd_q && (cnt_q == RE_LAST));
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
  import nand_bridge_pkg::*;
#(
  parameter int unsigned WE_LOW_CYC  = 3,
  parameter int unsigned RE_LOW_CYC  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              bus_ready_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [BYTE_W-1:0] nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [BYTE_W-1:0] nand_dq_i,
  input  logic              nand_rb_ni
);
  logic              pend_q, pend_rd_q, ready_q, ce_q, rd_mode_q;
  logic [WORD_W-1:0] rdata_q;
  logic              rb_sync, busy;
  logic              accept, take_wr, take_rd, seq_start, seq_done;
  op_e               wr_op;
  logic [BYTE_W-1:0] wr_byte;
  xfer_e             seq_kind;
  logic              wr_cycle;
  logic              unused_wbits;

  assign unused_wbits = ^{bus_wdata_i[BYTE_LSB-1:0], bus_wdata_i[OP_LSB-1:BYTE_LSB+BYTE_W]};

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(nand_rb_ni),
    .sync_o (rb_sync)
  );
  assign busy = ~rb_sync;

  assign wr_op   = op_e'(bus_wdata_i[OP_LSB +: OP_W]);
  assign wr_byte = bus_wdata_i[BYTE_LSB +: BYTE_W];
  assign accept  = (bus_wr_i || bus_rd_i) && !pend_q && !ready_q;
  assign take_wr = accept && bus_wr_i;
  assign take_rd = accept && !bus_wr_i;

  always_comb begin
    wr_cycle = 1'b0;
    seq_kind = XF_READ;
    unique case (wr_op)
      OP_CMD:   begin wr_cycle = 1'b1; seq_kind = XF_CMD;  end
      OP_ADDR:  begin wr_cycle = 1'b1; seq_kind = XF_ADDR; end
      OP_WRITE: begin wr_cycle = 1'b1; seq_kind = XF_DATA; end
      default:  ;
    endcase
    if (!take_wr) seq_kind = XF_READ;
  end

  assign seq_start = (take_wr && wr_cycle) || (take_rd && rd_mode_q);

  nand_pin_seq #(.WE_LOW_CYC(WE_LOW_CYC), .RE_LOW_CYC(RE_LOW_CYC)) u_pin_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(seq_start),
    .kind_i (seq_kind),
    .byte_i (wr_byte),
    .done_o (seq_done),
    .cle_o  (nand_cle_o),
    .ale_o  (nand_ale_o),
    .we_no  (nand_we_no),
    .re_no  (nand_re_no),
    .dq_o   (nand_dq_o),
    .dq_oe_o(nand_dq_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      pend_rd_q <= 1'b0;
      ready_q   <= 1'b0;
      ce_q      <= 1'b0;
      rd_mode_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ready_q <= 1'b0;
      if (take_wr) begin
        ce_q <= bus_wdata_i[CE_BIT];
        if (wr_cycle) begin
          rd_mode_q <= 1'b0;
          pend_q    <= 1'b1;
          pend_rd_q <= 1'b0;
        end else begin
          if (wr_op == OP_ARM_RD) rd_mode_q <= 1'b1;
          ready_q <= 1'b1;
          rdata_q <= pack_rd('0, busy);
        end
      end else if (take_rd) begin
        if (rd_mode_q) begin
          pend_q    <= 1'b1;
          pend_rd_q <= 1'b1;
        end else begin
          ready_q <= 1'b1;
          rdata_q <= pack_rd('0, busy);
        end
      end else if (seq_done) begin
        pend_q  <= 1'b0;
        ready_q <= 1'b1;
        rdata_q <= pack_rd(pend_rd_q ? nand_dq_i : '0, busy);
      end
    end
  end

  assign bus_ready_o = ready_q;
  assign bus_rdata_o = rdata_q;
  assign nand_ce_no  = ~ce_q;
endmodule

module nand_reg_bridge_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_ready_o,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_no,
  input logic       nand_re_no,
  input logic [7:0] nand_dq_o,
  input logic       nand_dq_oe_o
);
  p_cle_ale_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  p_we_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nand_we_no) |-> nand_dq_oe_o && $past(nand_dq_oe_o) && $stable(nand_dq_o)
                          && $stable(nand_cle_o) && $stable(nand_ale_o));

  p_we_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_we_no) |-> nand_dq_oe_o && $stable(nand_dq_o)
                          && $stable(nand_cle_o) && $stable(nand_ale_o));

  p_latch_drives_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_cle_o || nand_ale_o || !nand_we_no) |-> nand_dq_oe_o);

  p_read_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o && nand_we_no);

  p_ready_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o |=> !bus_ready_o);
endmodule

bind nand_reg_bridge nand_reg_bridge_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_ready_o (bus_ready_o),
  .nand_cle_o  (nand_cle_o),
  .nand_ale_o  (nand_ale_o),
  .nand_we_no  (nand_we_no),
  .nand_re_no  (nand_re_no),
  .nand_dq_o   (nand_dq_o),
  .nand_dq_oe_o(nand_dq_oe_o)
);

// File: tb/nand_reg_bridge_tb_top.sv
module nand_reg_bridge_tb_top;
  localparam int unsigned WE_LOW = 2;
  localparam int unsigned RE_LOW = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        ready, ce_n, cle, ale, we_n, re_n, oe, rb_n = 1'b1;
  logic [7:0]  dq_o, dq_i = '0;

  int n_chk = 0, n_bad = 0, cyc = 0, we_pulses = 0, re_pulses = 0;
  bit done = 0;
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  nand_reg_bridge #(.WE_LOW_CYC(WE_LOW), .RE_LOW_CYC(RE_LOW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_ready_o(ready), .nand_ce_no(ce_n), .nand_cle_o(cle),
    .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_o),
    .nand_dq_oe_o(oe), .nand_dq_i(dq_i), .nand_rb_ni(rb_n));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: measures strobes and pops the write-cycle scoreboard
  initial begin
    int we_low = 0, re_low = 0;
    logic we_prev = 1'b1, re_prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!we_n) we_low++;
      if (!re_n) re_low++;
      if (we_n && !we_prev) begin
        we_pulses++;
        check("R6 we low width", we_low, WE_LOW);
        if (exp_q.size() == 0) check("R2/R3/R4 unexpected write pulse", {cle, ale, dq_o}, '1);
        else check("R2/R3/R4 latch+byte", {22'd0, cle, ale, dq_o}, {22'd0, exp_q.pop_front()});
        we_low = 0;
      end
      if (re_n && !re_prev) begin
        re_pulses++;
        check("R8 re low width", re_low, RE_LOW);
        re_low = 0;
      end
      we_prev = we_n;
      re_prev = re_n;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  task automatic bus_write(input logic [31:0] w);
    @(negedge clk);
    wr = 1'b1; wdata = w;
    do @(negedge clk); while (!ready);
    wr = 1'b0;
    @(negedge clk);
    check("R12 ready one clock", {31'd0, ready}, 32'd0);
  endtask

  task automatic bus_read(output logic [31:0] r);
    @(negedge clk);
    rd = 1'b1;
    do @(negedge clk); while (!ready);
    r = rdata;
    rd = 1'b0;
    @(negedge clk);
    check("R12 ready one clock", {31'd0, ready}, 32'd0);
  endtask

  function automatic logic [31:0] mk(input logic ce, input logic [2:0] op, input logic [7:0] b);
    return {ce, op, 4'h0, b, 16'h0};
  endfunction

  initial begin
    logic [31:0] r;
    int p;
    repeat (3) @(negedge clk);
    check("R1 pins after reset", {26'd0, ce_n, we_n, re_n, cle, ale, oe},
          {26'd0, 6'b111000});
    check("R1 ready low", {31'd0, ready}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 command cycle
    exp_q.push_back({2'b10, 8'h70});
    bus_write(mk(1, 3'd0, 8'h70));
    check("R5 ce low after bit31 set", {31'd0, ce_n}, 32'd0);
    // R3 address cycle
    exp_q.push_back({2'b01, 8'h5A});
    bus_write(mk(1, 3'd1, 8'h5A));
    // R4 data writes, one per register write
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back({2'b00, 8'hC3 + 8'(i * 17)});
      bus_write(mk(1, 3'd3, 8'hC3 + 8'(i * 17)));
    end
    repeat (2) @(negedge clk);
    check("R4 one pulse per write", we_pulses, 6);
    check("R7 bus released when idle", {31'd0, oe}, 32'd0);

    // R9 read without read mode
    p = re_pulses;
    bus_read(r);
    check("R9 no-mode read data", r, 32'h0);
    check("R9 no re pulse", re_pulses, p);

    // R8 read mode
    bus_write(mk(1, 3'd2, 8'h00));
    check("R8 arm makes no write pulse", we_pulses, 6);
    dq_i = 8'hA5;
    bus_read(r);
    check("R8 read byte A5", r, 32'h00A5_0000);
    dq_i = 8'h3C;
    bus_read(r);
    check("R8 read byte 3C", r, 32'h003C_0000);
    check("R8 one re pulse per read", re_pulses, p + 2);
    check("R7 released after read", {31'd0, oe}, 32'd0);

    // R11 reserved opcode keeps read mode, changes ce only
    bus_write(mk(0, 3'd5, 8'hEE));
    check("R11 reserved op ce follows bit31", {31'd0, ce_n}, 32'd1);
    check("R11 reserved op no write pulse", we_pulses, 6);
    dq_i = 8'h81;
    bus_read(r);
    check("R11 read mode kept", r, 32'h0081_0000);
    check("R11 read pulse still fires", re_pulses, p + 3);

    // R9 command clears read mode; R5 ce high when bit31 clear
    exp_q.push_back({2'b10, 8'hFF});
    bus_write(mk(0, 3'd0, 8'hFF));
    check("R5 ce high after bit31 clear", {31'd0, ce_n}, 32'd1);
    bus_read(r);
    check("R9 read mode cleared by command", re_pulses, p + 3);
    check("R9 cleared read data", r, 32'h0);

    // R10 busy flag
    rb_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(r);
    check("R10 busy reads 1", r, 32'h0000_8000);
    rb_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(r);
    check("R10 ready reads 0", r, 32'h0);

    // R12 write wins over simultaneous read
    exp_q.push_back({2'b00, 8'h42});
    @(negedge clk);
    wr = 1'b1; rd = 1'b1; wdata = mk(1, 3'd3, 8'h42);
    do @(negedge clk); while (!ready);
    wr = 1'b0;
    do @(negedge clk); while (!ready);
    rd = 1'b0;
    check("R12 write first then read, read no pulse", re_pulses, p + 3);

    repeat (4) @(negedge clk);
    check("R2/R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule